// File: doc/BRIEF.md
# Reset Sequencer with Cause Capture

This block turns every reset request into one timed sequence on the PLL clock. A request can come from one of five internal detectors (power-on, low voltage, clock monitor, watchdog, illegal address) or from the board, which pulls the shared open-drain reset line low. The block first pulls that line low itself for a fixed drive period. It then lets the line go and keeps the chip in reset for a fixed settle period. At the end of the settle period it reads the line. A line that is still low means something outside is holding it, so the cause becomes the external pin.

The controller has three named states. `ST_IDLE` means no reset is in progress. `ST_DRIVE` means the line is driven low and the drive timer runs. `ST_SETTLE` means the line is released and the settle timer runs.

The transitions are:
- start: `ST_IDLE` to `ST_DRIVE` on a new internal request or a low line.
- restart: `ST_DRIVE` or `ST_SETTLE` back to `ST_DRIVE`, reloading the drive timer, on a new internal request.
- release: `ST_DRIVE` to `ST_SETTLE` when the drive timer expires.
- sample: `ST_SETTLE` to `ST_IDLE` when the settle timer expires, reading the line as it goes.

The power-on request works asynchronously and forces `ST_DRIVE`. A 3-bit cause code, used for vector selection, stays stable between sequences.

Top module: `rstgen_top`

## Requirements
- R1: In `ST_IDLE`, a rising edge on any synchronous internal request, or a low `pin_level`, moves the block to `ST_DRIVE` at the next clock edge. `pin_drive_low` and `sys_reset` are then both 1.
- R2: `pin_drive_low` stays 1 for exactly ASSERT_CYCLES (default 512) clock cycles after the last start or restart, and then goes to 0.
- R3: After the drive period, `sys_reset` stays 1 for exactly SETTLE_CYCLES (default 256) more cycles with the pin released, and then goes to 0.
- R4: At the sampling edge that ends `ST_SETTLE`, a low `pin_level` sets `cause` to 5 (external pin).
- R5: Otherwise `cause` names the highest-priority internal source seen in the sequence. The codes in priority order are power-on 0, low voltage 1, clock monitor 2, watchdog 3, illegal address 4. A sequence started only by a low pin gets code 5.
- R6: A rising edge on an internal request during `ST_DRIVE` or `ST_SETTLE` restarts a full drive period from that edge. `cause` changes only if the new source has higher priority.
- R7: While `req_por` is 1, the block holds `ST_DRIVE` with `cause` = 0. After `req_por` falls, the drive lasts ASSERT_CYCLES cycles.
- R8: In `ST_IDLE`, `cause` holds its value, and an internal request held at 1 does not start a new sequence (only rising edges count).
- R9: `sys_reset` is 1 whenever `pin_drive_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | PLL clock; all timing counts its cycles |
| req_por | input | 1 | Power-on request, asynchronous, active high |
| req_lvr | input | 1 | Low-voltage request, active high |
| req_clkmon | input | 1 | Clock-monitor request, active high |
| req_wdog | input | 1 | Watchdog request, active high |
| req_illadr | input | 1 | Illegal-address request, active high |
| pin_level | input | 1 | Synchronized level of the reset line (0 = low) |
| pin_drive_low | output | 1 | Enable for the open-drain pull-down on the reset line |
| sys_reset | output | 1 | Chip-internal reset, active high |
| cause | output | 3 | Encoded reset cause (codes in R5 and R4) |

## Verification
The assertions assume three things about the inputs:
- `pin_level` is already synchronized to `clk_pll`.
- The line reads low whenever the block drives it.
- Internal requests change only between clock edges.

The bench meets these assumptions with a line model built as a wired-AND of the block's own drive and an external hold. All stimulus is applied on falling edges. The external hold is raised only in idle or during the settle window, and it is dropped right after the sampling edge, so no unintended restart follows.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRIVE  = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_t;

    typedef enum logic [2:0] {
        CAUSE_POR    = 3'd0,
        CAUSE_LVR    = 3'd1,
        CAUSE_CLKMON = 3'd2,
        CAUSE_WDOG   = 3'd3,
        CAUSE_ILLADR = 3'd4,
        CAUSE_EXTPIN = 3'd5
    } cause_t;

    // Number of synchronous internal request lines (all but power-on)
    localparam int unsigned NUM_SYNC_REQ = 4;

endpackage

// File: rtl/rstgen_reqdet.sv
// Rising-edge detection on the synchronous request lines plus a
// fixed-priority encoder. Index 0 has the highest priority; the code
// of index i is i+1 (code 0 is reserved for power-on).
module rstgen_reqdet
    import rstgen_pkg::*;
#(
    parameter int unsigned N = NUM_SYNC_REQ
) (
    input  logic         clk,
    input  logic         por,
    input  logic [N-1:0] req,
    output logic         new_req,
    output cause_t       new_code
);

    logic [N-1:0] req_q;
    logic [N-1:0] rise;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            req_q <= '0;
        end else begin
            req_q <= req;
        end
    end

    assign rise    = req & ~req_q;
    assign new_req = |rise;

    always_comb begin
        new_code = CAUSE_EXTPIN;
        for (int i = N - 1; i >= 0; i--) begin
            if (rise[i]) begin
                new_code = cause_t'(3'(i + 1));
            end
        end
    end

endmodule

// File: rtl/rstgen_timer.sv
// Loadable down-counter; zero flags the last cycle of an interval.
module rstgen_timer #(
    parameter int unsigned W         = 9,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         por,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            cnt_q <= RESET_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
    import rstgen_pkg::*;
#(
    parameter int unsigned ASSERT_CYCLES = 512,
    parameter int unsigned SETTLE_CYCLES = 256
) (
    input  logic       clk_pll,
    input  logic       req_por,
    input  logic       req_lvr,
    input  logic       req_clkmon,
    input  logic       req_wdog,
    input  logic       req_illadr,
    input  logic       pin_level,
    output logic       pin_drive_low,
    output logic       sys_reset,
    output logic [2:0] cause
);

    localparam int unsigned MAXC = (ASSERT_CYCLES > SETTLE_CYCLES) ? ASSERT_CYCLES : SETTLE_CYCLES;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DRIVE_LOAD  = CW'(ASSERT_CYCLES - 1);
    localparam logic [CW-1:0] SETTLE_LOAD = CW'(SETTLE_CYCLES - 1);

    seq_state_t state_q, state_d;
    cause_t     cause_q, cause_d;
    logic       tmr_load;
    logic [CW-1:0] tmr_val;
    logic       tmr_zero;
    logic       new_req;
    cause_t     new_code;
    logic [NUM_SYNC_REQ-1:0] sync_req;

    // Index order is the priority order
    assign sync_req = {req_illadr, req_wdog, req_clkmon, req_lvr};

    rstgen_reqdet #(.N(NUM_SYNC_REQ)) u_reqdet (
        .clk      (clk_pll),
        .por      (req_por),
        .req      (sync_req),
        .new_req  (new_req),
        .new_code (new_code)
    );

    rstgen_timer #(.W(CW), .RESET_VAL(DRIVE_LOAD)) u_timer (
        .clk      (clk_pll),
        .por      (req_por),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // State register
    always_ff @(posedge clk_pll or posedge req_por) begin
        if (req_por) begin
            state_q <= ST_DRIVE;
            cause_q <= CAUSE_POR;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // Next state, timer control and cause update
    always_comb begin
        state_d  = state_q;
        cause_d  = cause_q;
        tmr_load = 1'b0;
        tmr_val  = DRIVE_LOAD;
        unique case (state_q)
            ST_IDLE: begin
                if (new_req || !pin_level) begin      // start
                    state_d  = ST_DRIVE;
                    tmr_load = 1'b1;
                    cause_d  = new_req ? new_code : CAUSE_EXTPIN;
                end
            end
            ST_DRIVE: begin
                if (new_req) begin                     // restart
                    tmr_load = 1'b1;
                    if (new_code < cause_q) cause_d = new_code;
                end else if (tmr_zero) begin           // release
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LOAD;
                end
            end
            ST_SETTLE: begin
                if (new_req) begin                     // restart
                    state_d  = ST_DRIVE;
                    tmr_load = 1'b1;
                    if (new_code < cause_q) cause_d = new_code;
                end else if (tmr_zero) begin           // sample
                    state_d = ST_IDLE;
                    if (!pin_level) cause_d = CAUSE_EXTPIN;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        pin_drive_low = (state_q == ST_DRIVE);
        sys_reset     = (state_q != ST_IDLE);
        cause         = cause_q;
    end

endmodule

// File: rtl/rstgen_chk.sv
module rstgen_chk #(
    parameter int unsigned SETTLE_CYCLES = 256
) (
    input logic       clk,
    input logic       por,
    input logic       drv,
    input logic       rst,
    input logic [2:0] cause,
    input logic       pin_level
);

    localparam int unsigned SW = $clog2(SETTLE_CYCLES + 2);
    logic [SW-1:0] settle_cnt;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            settle_cnt <= '0;
        end else if (rst && !drv) begin
            if (settle_cnt != '1) settle_cnt <= settle_cnt + 1'b1;
        end else begin
            settle_cnt <= '0;
        end
    end

    assert_drive_implies_reset_R9: assert property (@(posedge clk) disable iff (por)
        drv |-> rst);

    assert_start_in_drive_R1: assert property (@(posedge clk) disable iff (por)
        $rose(rst) |-> drv);

    assert_settle_bounded_R3: assert property (@(posedge clk) disable iff (por)
        settle_cnt <= SW'(SETTLE_CYCLES));

    assert_release_to_settle_R2: assert property (@(posedge clk) disable iff (por)
        $fell(drv) |-> rst);

    assert_ext_at_sample_R4: assert property (@(posedge clk) disable iff (por)
        ($fell(rst) && !$past(pin_level)) |-> (cause == 3'd5));

    assert_cause_hold_idle_R8: assert property (@(posedge clk) disable iff (por)
        ($past(!rst) && !rst) |-> $stable(cause));

    assert_cause_legal_R5: assert property (@(posedge clk) disable iff (por)
        cause <= 3'd5);

endmodule

bind rstgen_top rstgen_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk       (clk_pll),
    .por       (req_por),
    .drv       (pin_drive_low),
    .rst       (sys_reset),
    .cause     (cause),
    .pin_level (pin_level)
);

// File: tb/rstgen_top_bench.sv
module rstgen_top_bench;

    localparam int ASSERT_CYCLES = 512;
    localparam int SETTLE_CYCLES = 256;

    logic clk = 1'b0;
    logic req_por, req_lvr, req_clkmon, req_wdog, req_illadr;
    logic ext_hold;
    logic pin_level;
    logic pin_drive_low, sys_reset;
    logic [2:0] cause;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // Open-drain line: low if the block or the board pulls it
    assign pin_level = ~(pin_drive_low | ext_hold);

    rstgen_top #(.ASSERT_CYCLES(ASSERT_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_rstgen_top (
        .clk_pll       (clk),
        .req_por       (req_por),
        .req_lvr       (req_lvr),
        .req_clkmon    (req_clkmon),
        .req_wdog      (req_wdog),
        .req_illadr    (req_illadr),
        .pin_level     (pin_level),
        .pin_drive_low (pin_drive_low),
        .sys_reset     (sys_reset),
        .cause         (cause)
    );

    // Vector: {mask[3:0] = illadr,wdog,clkmon,lvr ; ext at sample ; expected cause[2:0]}
    localparam int NV = 8;
    localparam logic [7:0] VEC [NV] = '{
        {4'b0001, 1'b0, 3'd1},
        {4'b0010, 1'b0, 3'd2},
        {4'b0100, 1'b0, 3'd3},
        {4'b1000, 1'b0, 3'd4},
        {4'b1010, 1'b0, 3'd2},
        {4'b0101, 1'b0, 3'd1},
        {4'b0100, 1'b1, 3'd5},
        {4'b1111, 1'b0, 3'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_mask(input logic [3:0] m);
        req_lvr    = m[0];
        req_clkmon = m[1];
        req_wdog   = m[2];
        req_illadr = m[3];
    endtask

    // Called at the falling edge right after the start/restart edge
    task automatic measure(input bit ext_at_sample, input logic [2:0] exp_cause, input string tag);
        int dcnt = 0;
        int scnt = 0;
        check(pin_drive_low && sys_reset, {tag, " R1/R9 start"}, {pin_drive_low, sys_reset}, 3);
        while (pin_drive_low) begin
            if (!sys_reset) check(1'b0, {tag, " R9"}, 0, 1);
            dcnt++;
            @(negedge clk);
        end
        check(dcnt == ASSERT_CYCLES, {tag, " R2 drive length"}, dcnt, ASSERT_CYCLES);
        if (ext_at_sample) ext_hold = 1'b1;
        while (sys_reset) begin
            scnt++;
            @(negedge clk);
        end
        ext_hold = 1'b0;
        check(scnt == SETTLE_CYCLES, {tag, " R3 settle length"}, scnt, SETTLE_CYCLES);
        check(cause == exp_cause, {tag, ext_at_sample ? " R4 cause" : " R5 cause"}, cause, exp_cause);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        req_por = 1'b1;
        set_mask(4'b0000);
        ext_hold = 1'b0;
        repeat (3) @(negedge clk);
        // Reset state, R7
        check(pin_drive_low && sys_reset, "R7 por holds drive", {pin_drive_low, sys_reset}, 3);
        check(cause == 3'd0, "R7 por cause", cause, 0);
        req_por = 1'b0;
        measure(1'b0, 3'd0, "R7 por release");

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_mask(VEC[i][7:4]);
            @(negedge clk);
            set_mask(4'b0000);
            measure(VEC[i][3], VEC[i][2:0], $sformatf("vec%0d", i));
        end

        // External pin start, R1 and R5 (pin-only sequence -> 5)
        @(negedge clk);
        ext_hold = 1'b1;
        @(negedge clk);
        ext_hold = 1'b0;
        measure(1'b0, 3'd5, "ext start R1");

        // Restart with higher priority, R6
        @(negedge clk);
        req_wdog = 1'b1;
        @(negedge clk);
        req_wdog = 1'b0;
        repeat (100) @(negedge clk);
        req_lvr = 1'b1;
        @(negedge clk);
        req_lvr = 1'b0;
        measure(1'b0, 3'd1, "R6 restart in drive");

        // Restart from settle with lower priority, R6
        @(negedge clk);
        req_lvr = 1'b1;
        @(negedge clk);
        req_lvr = 1'b0;
        while (pin_drive_low) @(negedge clk);
        repeat (10) @(negedge clk);
        check(sys_reset && !pin_drive_low, "R3 in settle", {pin_drive_low, sys_reset}, 1);
        req_illadr = 1'b1;
        @(negedge clk);
        req_illadr = 1'b0;
        measure(1'b0, 3'd1, "R6 restart in settle");

        // Held level does not retrigger; cause holds, R8
        @(negedge clk);
        req_wdog = 1'b1;
        @(negedge clk);
        measure(1'b0, 3'd3, "R8 held start");
        repeat (50) @(negedge clk);
        check(!sys_reset && !pin_drive_low, "R8 no retrigger", {pin_drive_low, sys_reset}, 0);
        check(cause == 3'd3, "R8 cause held", cause, 3);
        req_wdog = 1'b0;
        repeat (5) @(negedge clk);
        check(!sys_reset, "R8 fall ignored", sys_reset, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule